// File: doc/BRIEF.md
# SMBus Slave with Register Pointer and Grouped Flash Staging

This block is a bus slave that follows SMBus/I2C framing. It takes raw SCL and SDA levels, samples them with the system clock, and pulls SDA low through an open-drain enable. An internal byte pointer selects the location for every access. A send-byte frame loads the pointer or runs a command. A receive-byte frame returns the byte at the pointer and then steps the pointer forward. A write-byte frame stores one data byte at the location its command byte names.

Two regions sit behind the pointer. The first is a register file at pointer values `0 .. REG_DEPTH-1`. The second is a nonvolatile array model at `FLASH_BASE .. FLASH_BASE+FLASH_DEPTH-1`. Writes into the nonvolatile region pass through an 8-byte staging buffer, and the array changes only when an aligned group of eight bytes is complete.

Three command codes have fixed meanings. `A5h` and `A6h` are accepted as the start of a block transfer, but no block payload is moved. `A7h` performs a soft reboot.

The controller has these states:

- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the slave address.
- `ST_CMD`: shifting in the command or pointer byte.
- `ST_CMD_ACK`: acknowledging the command byte.
- `ST_DATA`: shifting in the data byte.
- `ST_DATA_ACK`: acknowledging the data byte.
- `ST_TX`: driving a read byte.
- `ST_TX_ACK`: sampling the master's acknowledge.
- `ST_IGNORE`: hands off the bus until the next START.

The transitions are as follows:

- START from any state enters `ST_ADDR`.
- STOP from any state enters `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match and to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK` goes to `ST_TX` for a read and to `ST_CMD` for a write.
- `ST_CMD` goes to `ST_CMD_ACK` if the byte is allowed and to `ST_IGNORE` (NACK) if not.
- `ST_CMD_ACK` goes to `ST_DATA`.
- `ST_DATA` goes to `ST_DATA_ACK` if the write is allowed and to `ST_IGNORE` (NACK) if not.
- `ST_DATA_ACK` goes to `ST_IGNORE`.
- `ST_TX` goes to `ST_TX_ACK`.
- `ST_TX_ACK` goes back to `ST_TX` on a master ACK and to `ST_IGNORE` on a master NACK.

Top module: `smb_ptr_slave`

## Requirements
- R1: After reset, `sda_oe`, `reboot` and `nv_err` are 0. The pointer is 0. Every register reads 00h, and every nonvolatile byte reads FFh.
- R2: An address byte whose upper 7 bits equal `SLAVE_ADDR` is ACKed (SDA low on the 9th clock). Bit 0 of that byte selects read (1) or write (0). Any other address gets no ACK, and `sda_oe` stays 0 for the rest of that frame until the next START.
- R3: A command byte that falls inside the register region or the nonvolatile region is ACKed and loads the pointer. Any other value, apart from A5h, A6h and A7h, is NACKed and leaves the pointer unchanged.
- R4: A5h and A6h are ACKed and leave the pointer unchanged. A data byte that follows them in the same frame is NACKed and stored nowhere.
- R5: A7h is ACKed. It raises `reboot` for exactly one clock, sets the pointer to 0, clears `nv_err` and empties the staging buffer.
- R6: The pointer is loaded only at the SCL fall that starts the slave's ACK. A STOP after the 8th bit of the command byte but before that fall leaves the pointer unchanged.
- R7: A read frame returns the byte at the pointer, MSB first. The pointer increments by one at the 9th clock of every byte sent, so repeated read frames return consecutive locations.
- R8: In a write frame, the first data byte is ACKed and stored at the pointer. A second data byte in the same frame is NACKed and not stored.
- R9: Nonvolatile writes collect in the staging buffer. The buffer starts only at an address whose 3 LSBs (relative to `FLASH_BASE`) are 000 and then accepts the following seven addresses in order. Array reads show the old contents until the 8th byte commits the whole group.
- R10: A nonvolatile write that is not the next expected byte of an aligned group is discarded and sets `nv_err`. `nv_err` stays set until a reboot.
- R11: `sda_oe` changes only while the synchronised SCL is low. It is released at the SCL fall that ends the ACK clock of a received byte.
- R12: A START or STOP at any point resets the bit counter. A repeated START in the middle of a byte is followed by a correctly framed transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reboot | output | 1 | One-clock pulse on an accepted A7h command |
| nv_err | output | 1 | Sticky flag for a discarded nonvolatile write |

## Verification
Two functions can collide on the same bus clock: STOP detection and the pointer load that happens when the slave begins its ACK. The bench provokes this by sending a command byte whose last bit is 0 and then raising SDA while SCL is still high after the 8th rising edge, so that the STOP arrives before the ACK fall. It then judges the outcome with a receive byte: the byte returned must come from the old pointer and not from the location named by the interrupted byte. A second collision is the 8th staged byte, where the commit and the error check decide in the same cycle. This is judged by reading the group back and by sampling `nv_err` after in-order and out-of-order sequences.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } smb_state_e;

    localparam logic [7:0] CMD_BLOCK_WR = 8'hA5;
    localparam logic [7:0] CMD_BLOCK_RD = 8'hA6;
    localparam logic [7:0] CMD_REBOOT   = 8'hA7;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Shift registers for the two lines; idle bus level is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    // SDA moves while SCL stays high: bus conditions.
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] waddr,
    input  logic [7:0] wdata,
    input  logic [7:0] raddr,
    output logic [7:0] rdata
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr[AW-1:0]] <= wdata;
        end
    end

    always_comb begin
        if (int'(raddr) < DEPTH) rdata = mem[raddr[AW-1:0]];
        else                     rdata = 8'hFF;
    end

endmodule

// File: rtl/smb_nv_stage.sv
module smb_nv_stage #(
    parameter int BASE  = 128,
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       we,
    input  logic [7:0] waddr,
    input  logic [7:0] wdata,
    input  logic [7:0] raddr,
    output logic [7:0] rdata,
    output logic       err
);

    localparam int AW = $clog2(DEPTH);
    localparam int GW = AW - 3;

    logic [7:0]    arr   [DEPTH];
    logic [7:0]    stage [8];
    logic [2:0]    idx;
    logic [GW-1:0] grp;
    logic [7:0]    woff;
    logic [7:0]    roff;
    logic          w_in;
    logic          accept;

    assign woff = waddr - 8'(BASE);
    assign roff = raddr - 8'(BASE);
    assign w_in = int'(woff) < DEPTH;

    // First byte must sit on an 8-byte boundary; later bytes follow in order.
    always_comb begin
        if (idx == 3'd0) accept = w_in && (woff[2:0] == 3'd0);
        else             accept = w_in && (woff[AW-1:3] == grp) && (woff[2:0] == idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) arr[i] <= 8'hFF;
            for (int k = 0; k < 8; k++) stage[k] <= 8'h00;
            idx <= '0;
            grp <= '0;
            err <= 1'b0;
        end else if (clear) begin
            idx <= '0;
            err <= 1'b0;
        end else if (we) begin
            if (accept) begin
                stage[idx] <= wdata;
                idx        <= idx + 3'd1;
                if (idx == 3'd0) grp <= woff[AW-1:3];
                if (idx == 3'd7) begin
                    for (int k = 0; k < 7; k++) arr[{grp, 3'(k)}] <= stage[k];
                    arr[{grp, 3'd7}] <= wdata;
                end
            end else begin
                err <= 1'b1;
            end
        end
    end

    always_comb begin
        if (int'(roff) < DEPTH) rdata = arr[roff[AW-1:0]];
        else                    rdata = 8'hFF;
    end

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
    import smb_ptr_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h52,
    parameter int         REG_DEPTH   = 16,
    parameter int         FLASH_BASE  = 128,
    parameter int         FLASH_DEPTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    output logic reboot,
    output logic nv_err
);

    localparam int FLASH_END = FLASH_BASE + FLASH_DEPTH;

    smb_state_e state, state_nx;

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0] bit_cnt;
    logic [7:0] sh;
    logic [7:0] tx;
    logic [7:0] ptr;
    logic       is_read;
    logic       blk;
    logic       reboot_q;
    logic [7:0] reg_rd, nv_rd, rd_data;
    logic       byte_done, ack_done;
    logic       addr_hit, cmd_blk, cmd_rb, cmd_loc, cmd_ok, data_ok;
    logic       reg_we, nv_we;

    function automatic logic in_reg(input logic [7:0] a);
        return int'(a) < REG_DEPTH;
    endfunction

    function automatic logic in_nv(input logic [7:0] a);
        return (int'(a) >= FLASH_BASE) && (int'(a) < FLASH_END);
    endfunction

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_regfile #(.DEPTH(REG_DEPTH)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (ptr),
        .wdata (sh),
        .raddr (ptr),
        .rdata (reg_rd)
    );

    smb_nv_stage #(.BASE(FLASH_BASE), .DEPTH(FLASH_DEPTH)) u_nv (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (reboot_q),
        .we    (nv_we),
        .waddr (ptr),
        .wdata (sh),
        .raddr (ptr),
        .rdata (nv_rd),
        .err   (nv_err)
    );

    // Decode helpers shared by the next-state and output processes.
    assign rd_data   = in_reg(ptr) ? reg_rd : nv_rd;
    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign ack_done  = scl_fall && (bit_cnt == 4'd1);
    assign addr_hit  = (sh[7:1] == SLAVE_ADDR);
    assign cmd_blk   = (sh == CMD_BLOCK_WR) || (sh == CMD_BLOCK_RD);
    assign cmd_rb    = (sh == CMD_REBOOT);
    assign cmd_loc   = in_reg(sh) || in_nv(sh);
    assign cmd_ok    = cmd_blk || cmd_rb || cmd_loc;
    assign data_ok   = !blk && (in_reg(ptr) || in_nv(ptr));
    assign reg_we    = (state == ST_DATA) && byte_done && data_ok && in_reg(ptr);
    assign nv_we     = (state == ST_DATA) && byte_done && data_ok && in_nv(ptr);
    assign reboot    = reboot_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transition logic.
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_nx = state;
                ST_ADDR:     if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (ack_done)  state_nx = is_read ? ST_TX : ST_CMD;
                ST_CMD:      if (byte_done) state_nx = cmd_ok ? ST_CMD_ACK : ST_IGNORE;
                ST_CMD_ACK:  if (ack_done)  state_nx = ST_DATA;
                ST_DATA:     if (byte_done) state_nx = data_ok ? ST_DATA_ACK : ST_IGNORE;
                ST_DATA_ACK: if (ack_done)  state_nx = ST_IGNORE;
                ST_TX:       if (byte_done) state_nx = ST_TX_ACK;
                ST_TX_ACK: begin
                    if (scl_rise && sda_s) state_nx = ST_IGNORE;
                    else if (ack_done)     state_nx = ST_TX;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Outputs and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            sh       <= '0;
            tx       <= '0;
            ptr      <= '0;
            is_read  <= 1'b0;
            blk      <= 1'b0;
            sda_oe   <= 1'b0;
            reboot_q <= 1'b0;
        end else begin
            reboot_q <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                blk     <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_CMD, ST_DATA: begin
                        if (scl_rise) begin
                            sh      <= {sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                sda_oe  <= addr_hit;
                                is_read <= sh[0];
                            end else if (state == ST_CMD) begin
                                sda_oe <= cmd_ok;
                                if (cmd_loc) begin
                                    ptr <= sh;
                                    blk <= 1'b0;
                                end else if (cmd_blk) begin
                                    blk <= 1'b1;
                                end else if (cmd_rb) begin
                                    ptr      <= '0;
                                    blk      <= 1'b0;
                                    reboot_q <= 1'b1;
                                end
                            end else begin
                                sda_oe <= data_ok;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_CMD_ACK, ST_DATA_ACK: begin
                        if (scl_rise) bit_cnt <= 4'd1;
                        if (ack_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR_ACK && is_read) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
                        if (scl_fall && bit_cnt != 4'd0) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                            end else begin
                                sda_oe <= ~tx[6];
                                tx     <= {tx[6:0], 1'b0};
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            ptr     <= ptr + 8'd1;
                            bit_cnt <= 4'd1;
                        end
                        if (ack_done) begin
                            bit_cnt <= '0;
                            tx      <= rd_data;
                            sda_oe  <= ~rd_data[7];
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_ptr_chk.sv
module smb_ptr_chk
    import smb_ptr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       scl_rise,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       reboot,
    input logic       nv_err,
    input logic [7:0] ptr,
    input smb_state_e state
);

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det || stop_det)) |-> !scl_s); // R11

    AST_QUIET_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe); // R2

    AST_REBOOT_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        reboot |=> !reboot); // R5

    AST_REBOOT_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reboot |-> (ptr == 8'd0)); // R5

    AST_PTR_AT_SCL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> $past(scl_rise || scl_fall)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nv_err) |-> $past(reboot)); // R10

endmodule

bind smb_ptr_slave smb_ptr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .reboot    (reboot),
    .nv_err    (nv_err),
    .ptr       (ptr),
    .state     (state)
);

// File: tb/sim_smb_ptr_slave.sv
module sim_smb_ptr_slave;

    localparam logic [7:0] AW_BYTE = 8'hA4;   // 7'h52 with write bit
    localparam logic [7:0] AR_BYTE = 8'hA5;   // 7'h52 with read bit
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, reboot, nv_err;
    logic sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int rb_cnt = 0;
    bit oe_seen = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smb_ptr_slave u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_m),
        .sda_in (sda_line),
        .sda_oe (sda_oe),
        .reboot (reboot),
        .nv_err (nv_err)
    );

    always @(negedge clk) begin
        if (reboot) rb_cnt++;
        if (sda_oe) oe_seen = 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b;    hold(Q);
        scl_m = 1'b1; hold(Q);
        s = sda_line; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        acked = (s == 1'b0);
    endtask

    task automatic get_byte(input logic m_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(!m_ack, s);
    endtask

    task automatic tx_send(input logic [7:0] cmd, output logic a_cmd);
        logic a;
        bus_start();
        put_byte(AW_BYTE, a);
        put_byte(cmd, a_cmd);
        bus_stop();
    endtask

    task automatic tx_write(input logic [7:0] cmd, input logic [7:0] d, output logic a_d);
        logic a;
        bus_start();
        put_byte(AW_BYTE, a);
        put_byte(cmd, a);
        put_byte(d, a_d);
        bus_stop();
    endtask

    task automatic tx_recv(output logic [7:0] v);
        logic a;
        bus_start();
        put_byte(AR_BYTE, a);
        get_byte(1'b0, v);
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 reboot", reboot, 0);
        chk("R1 nv_err", nv_err, 0);
        tx_recv(v);
        chk("R1 reg0 reset value", v, 8'h00);
    endtask

    task automatic t_regwrite();
        logic a, a1, a2;
        logic [7:0] v;
        tx_write(8'h03, 8'h5A, a);
        chk("R8 first data ack", a, 1);
        bus_start();
        put_byte(AW_BYTE, a);
        put_byte(8'h04, a);
        hold(2);
        chk("R11 released after ack clock", sda_oe, 0);
        put_byte(8'h11, a1);
        put_byte(8'h22, a2);
        bus_stop();
        chk("R8 second data nack", a2, 0);
        tx_send(8'h03, a);
        tx_recv(v);
        chk("R8 reg3 stored", v, 8'h5A);
        tx_send(8'h04, a);
        tx_recv(v);
        chk("R8 reg4 keeps first byte", v, 8'h11);
    endtask

    task automatic t_recv_seq();
        logic a;
        logic [7:0] v;
        tx_write(8'h05, 8'hA1, a);
        tx_write(8'h06, 8'hB2, a);
        tx_write(8'h07, 8'hC3, a);
        tx_write(8'h0A, 8'h77, a);
        tx_send(8'h05, a);
        chk("R3 allowed pointer ack", a, 1);
        tx_recv(v); chk("R7 read at 5", v, 8'hA1);
        tx_recv(v); chk("R7 read at 6", v, 8'hB2);
        tx_recv(v); chk("R7 read at 7", v, 8'hC3);
    endtask

    task automatic t_badcmd();
        logic a;
        logic [7:0] v;
        tx_send(8'h05, a);
        tx_send(8'h40, a);
        chk("R3 disallowed nack", a, 0);
        tx_recv(v);
        chk("R3 pointer unchanged", v, 8'hA1);
    endtask

    task automatic t_block();
        logic a, ad;
        logic [7:0] v;
        tx_send(8'h05, a);
        bus_start();
        put_byte(AW_BYTE, a);
        put_byte(8'hA5, a);
        chk("R4 A5 ack", a, 1);
        put_byte(8'h99, ad);
        bus_stop();
        chk("R4 data after A5 nack", ad, 0);
        tx_send(8'hA6, a);
        chk("R4 A6 ack", a, 1);
        tx_recv(v);
        chk("R4 pointer unchanged", v, 8'hA1);
    endtask

    task automatic t_stop_early();
        logic a, s;
        logic [7:0] v;
        tx_send(8'h05, a);
        bus_start();
        put_byte(AW_BYTE, a);
        for (int i = 7; i >= 1; i--) clk_bit(((8'h0A >> i) & 8'h01) != 0, s);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
        tx_recv(v);
        chk("R6 stop before ack keeps pointer", v, 8'hA1);
    endtask

    task automatic t_addr_miss();
        logic a1, a2;
        logic [7:0] v;
        bus_start();
        oe_seen = 1'b0;
        put_byte(8'h44, a1);
        put_byte(8'h06, a2);
        bus_stop();
        chk("R2 wrong address no ack", a1, 0);
        chk("R2 bus ignored after miss", oe_seen, 0);
        tx_send(8'h06, a1);
        chk("R2 address match ack", a1, 1);
        tx_recv(v);
        chk("R2 frame after miss reads 6", v, 8'hB2);
    endtask

    task automatic t_restart();
        logic a, s;
        logic [7:0] v;
        bus_start();
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        clk_bit(1'b1, s);
        bus_start();
        put_byte(AW_BYTE, a);
        chk("R12 address ack after restart", a, 1);
        put_byte(8'h07, a);
        bus_stop();
        tx_recv(v);
        chk("R12 pointer from restarted frame", v, 8'hC3);
    endtask

    task automatic t_flash();
        logic a;
        logic [7:0] v;
        for (int i = 0; i < 7; i++) tx_write(8'h80 + 8'(i), 8'h10 + 8'(i), a);
        tx_send(8'h80, a);
        tx_recv(v);
        chk("R9 no commit before 8th byte", v, 8'hFF);
        tx_write(8'h87, 8'h17, a);
        chk("R9 nv_err clear on ordered group", nv_err, 0);
        tx_send(8'h80, a);
        for (int i = 0; i < 8; i++) begin
            tx_recv(v);
            chk("R9 committed group byte", v, 8'h10 + 8'(i));
        end
    endtask

    task automatic t_flash_err();
        logic a;
        logic [7:0] v;
        tx_write(8'h88, 8'h21, a);
        chk("R10 aligned start no error", nv_err, 0);
        tx_write(8'h8A, 8'h23, a);
        chk("R10 out of order sets error", nv_err, 1);
        tx_write(8'h89, 8'h22, a);
        chk("R10 error sticky", nv_err, 1);
        tx_send(8'h88, a);
        tx_recv(v);
        chk("R10 discarded group not visible", v, 8'hFF);
    endtask

    task automatic t_reboot();
        logic a;
        logic [7:0] v;
        int rb0;
        tx_write(8'h00, 8'h3C, a);
        tx_send(8'h06, a);
        rb0 = rb_cnt;
        tx_send(8'hA7, a);
        chk("R5 A7 ack", a, 1);
        chk("R5 reboot one clock", rb_cnt - rb0, 1);
        chk("R5 nv_err cleared", nv_err, 0);
        tx_recv(v);
        chk("R5 pointer zero", v, 8'h3C);
        tx_write(8'h8B, 8'h55, a);
        chk("R5 staging emptied", nv_err, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        hold(5);
        rst_n = 1'b1;
        hold(5);
        t_reset();
        t_regwrite();
        t_recv_seq();
        t_badcmd();
        t_block();
        t_stop_early();
        t_addr_miss();
        t_restart();
        t_flash();
        t_flash_err();
        t_reboot();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule